// File: doc/BRIEF.md
# SDRAM Power-Up Command Port

This block is a memory-mapped bus slave placed in front of a DDR SDRAM while the memory is being brought up. As long as it is in init mode, every bus write is translated into exactly one raw SDRAM command. The write carries no payload of interest. The command, the bank and the row address are all cut from fixed fields of the write address. Software therefore walks the power-up sequence (clock enable, precharge all, mode register loads, auto refreshes) by writing to a series of computed addresses.

The first bus read seen in init mode switches the block for good into normal mode. It raises a flag that tells the downstream memory controller it may take over. From then on, writes are no longer decoded. The data lanes of the bus are not routed through this block. The row width and the position of the row field are parameters, so parts with 12, 13 or 14 row lines are covered. The bank field always sits in the two bits just below the row field.

Top module: `sdram_init_port`

## Requirements
- R1: One cycle after an init-mode write, `mem_addr` equals write address bits [ROW_LSB+ROW_W-1:ROW_LSB] (default bits 25:13, 13 lines).
- R2: One cycle after an init-mode write, `mem_ba` equals write address bits [ROW_LSB-1:ROW_LSB-2] (default bits 12:11).
- R3: One cycle after an init-mode write, {`mem_ras_n`,`mem_cas_n`,`mem_we_n`} equals write address bits 6:4. The codes are NOP=111, PRECHARGE=010, AUTO REFRESH=001 and LOAD MODE=000, and every 3-bit value is passed through unchanged.
- R4: A decoded command is held on the pins for exactly one clock. On every cycle that does not follow an init-mode write, the command pins show NOP (111) and `mem_addr` and `mem_ba` are zero.
- R5: `bus_ready` pulses high for one cycle in the cycle after each init-mode write and is low otherwise.
- R6: `mem_cke` is low from reset until the first NOP is decoded. It goes high in the same cycle that NOP appears on the pins and stays high until reset.
- R7: A read (`bus_sel`=1, `bus_we`=0) sets `run_mode` from the next cycle on, and `run_mode` stays set until reset.
- R8: Once `run_mode` is set, writes leave the pins at NOP with zero address and bank, give no `bus_ready`, and do not change `mem_cke`.
- R9: During reset and in the first cycle after it, `run_mode`, `mem_cke`, `bus_ready`, `mem_addr` and `mem_ba` are all zero, and the command pins show NOP.
- R10: With ROW_W=12 and ROW_LSB=12, the row comes from address bits 23:12 and the bank from bits 11:10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle it is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_ready | output | 1 | One-cycle acknowledge of an init-mode write |
| mem_cke | output | 1 | SDRAM clock enable |
| mem_ras_n | output | 1 | SDRAM row strobe, active low |
| mem_cas_n | output | 1 | SDRAM column strobe, active low |
| mem_we_n | output | 1 | SDRAM write enable, active low |
| mem_ba | output | 2 | SDRAM bank address |
| mem_addr | output | ROW_W | SDRAM address lines |
| run_mode | output | 1 | Normal operation enabled for the downstream controller |

## Verification
Every result of an access is due exactly one clock after the edge that samples the strobe. This covers the command, bank and address pins, the ready pulse, the clock enable and the mode flag. The bench drives inputs on the falling edge, waits for the next rising edge, and samples one time unit after it. It then drops the strobe and samples again after the following edge to confirm that the pins are back at NOP. Random addresses come from a seeded generator. Expected pin values are cut from those addresses by bench functions for both the default and the 12-line instance.

// File: rtl/sip_pkg.sv
// Package: shared command codes and widths of the SDRAM power-up command port.
// Assumes command codes are the {RAS,CAS,WE} active-low triplet.
package sip_pkg;
    localparam int BANK_W = 2;
    localparam int CMD_W  = 3;
    typedef logic [CMD_W-1:0] cmd_t;
    localparam cmd_t CMD_NOP = 3'b111;
    localparam cmd_t CMD_PRE = 3'b010;
    localparam cmd_t CMD_REF = 3'b001;
    localparam cmd_t CMD_LMR = 3'b000;
endpackage

// File: rtl/sip_field_decode.sv
// Module: cuts row, bank and command fields out of a bus address.
// Assumes ADDR_W >= ROW_LSB+ROW_W, ROW_LSB >= BANK_W, and that the command
// field lies at CMD_LSB. Purely combinational.
module sip_field_decode
    import sip_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ROW_W   = 13,
    parameter int ROW_LSB = 13,
    parameter int CMD_LSB = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_W-1:0]  row,
    output logic [BANK_W-1:0] bank,
    output cmd_t              cmd
);
    localparam int BANK_LSB = ROW_LSB - BANK_W;

    // Field extraction by position.
    always_comb begin
        row  = addr[ROW_LSB +: ROW_W];
        bank = addr[BANK_LSB +: BANK_W];
        cmd  = addr[CMD_LSB +: CMD_W];
    end
endmodule

// File: rtl/sip_mode_ctrl.sv
// Module: holds the sticky normal-mode flag and the clock-enable latch.
// Assumes rd_strobe and nop_issue are single-cycle qualified strobes.
module sip_mode_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_strobe,
    input  logic nop_issue,
    output logic run_mode,
    output logic cke
);
    // Mode flag: set by the first read, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         run_mode <= 1'b0;
        else if (rd_strobe) run_mode <= 1'b1;
    end

    // Clock enable: raised by the first decoded NOP, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         cke <= 1'b0;
        else if (nop_issue) cke <= 1'b1;
    end

    assert_mode_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run_mode |=> run_mode);
    assert_cke_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);
    assert_cke_waits_nop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !nop_issue) |=> !cke);
endmodule

// File: rtl/sip_cmd_drive.sv
// Module: registers one command onto the SDRAM pins for a single clock and
// answers the bus with a one-cycle ready; idles at NOP with zero address.
// Assumes issue is already qualified by init mode.
module sip_cmd_drive
    import sip_pkg::*;
#(
    parameter int ROW_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [ROW_W-1:0]  row,
    input  logic [BANK_W-1:0] bank,
    input  cmd_t              cmd,
    output logic [ROW_W-1:0]  mem_addr,
    output logic [BANK_W-1:0] mem_ba,
    output cmd_t              cmd_q,
    output logic              ready
);
    // Pin register: load on issue, fall back to idle NOP otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !issue) begin
            mem_addr <= '0;
            mem_ba   <= '0;
            cmd_q    <= CMD_NOP;
        end else begin
            mem_addr <= row;
            mem_ba   <= bank;
            cmd_q    <= cmd;
        end
    end

    // Acknowledge: one pulse per accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) ready <= 1'b0;
        else        ready <= issue;
    end

    assert_idle_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> (cmd_q == CMD_NOP && mem_addr == '0 && mem_ba == '0));
    assert_ack_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> ready);
    assert_no_stray_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> !ready);
endmodule

// File: rtl/sdram_init_port.sv
// Module: SDRAM power-up command port. In init mode each bus write becomes
// one SDRAM command taken from address fields; the first read enters normal
// mode for good. Assumes single-cycle accesses: each cycle with bus_sel high
// is one access. Write data lanes bypass this block.
module sdram_init_port
    import sip_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ROW_W   = 13,
    parameter int ROW_LSB = 13,
    parameter int CMD_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ready,
    output logic              mem_cke,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [BANK_W-1:0] mem_ba,
    output logic [ROW_W-1:0]  mem_addr,
    output logic              run_mode
);
    logic [ROW_W-1:0]  f_row;
    logic [BANK_W-1:0] f_bank;
    cmd_t              f_cmd;
    cmd_t              cmd_q;
    logic              issue;
    logic              rd_strobe;
    logic              nop_issue;

    // Access qualification: writes decode only in init mode.
    always_comb begin
        issue     = bus_sel && bus_we && !run_mode;
        rd_strobe = bus_sel && !bus_we;
        nop_issue = issue && (f_cmd == CMD_NOP);
    end

    sip_field_decode #(
        .ADDR_W(ADDR_W), .ROW_W(ROW_W), .ROW_LSB(ROW_LSB), .CMD_LSB(CMD_LSB)
    ) u_decode (
        .addr(bus_addr), .row(f_row), .bank(f_bank), .cmd(f_cmd)
    );

    sip_mode_ctrl u_mode (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe),
        .nop_issue(nop_issue), .run_mode(run_mode), .cke(mem_cke)
    );

    sip_cmd_drive #(.ROW_W(ROW_W)) u_drive (
        .clk(clk), .rst_n(rst_n), .issue(issue), .row(f_row), .bank(f_bank),
        .cmd(f_cmd), .mem_addr(mem_addr), .mem_ba(mem_ba), .cmd_q(cmd_q),
        .ready(bus_ready)
    );

    // Pin split of the registered command triplet.
    always_comb begin
        {mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;
    end

    assert_cmd_from_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> ({mem_ras_n, mem_cas_n, mem_we_n} == $past(bus_addr[CMD_LSB +: CMD_W])));
    assert_row_from_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (mem_addr == $past(bus_addr[ROW_LSB +: ROW_W])));
    assert_normal_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run_mode |=> ({mem_ras_n, mem_cas_n, mem_we_n} == CMD_NOP && !bus_ready));
endmodule

// File: tb/sdram_init_port_bench.sv
module sdram_init_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0;
    logic bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;

    logic bus_ready, mem_cke, ras_n, cas_n, we_n, run_mode;
    logic [1:0]  mem_ba;
    logic [12:0] mem_addr;
    logic s_ready, s_cke, s_ras, s_cas, s_we, s_run;
    logic [1:0]  s_ba;
    logic [11:0] s_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit exp_cke = 1'b0;
    bit exp_run = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_init_port u_sdram_init_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_ready(bus_ready), .mem_cke(mem_cke),
        .mem_ras_n(ras_n), .mem_cas_n(cas_n), .mem_we_n(we_n),
        .mem_ba(mem_ba), .mem_addr(mem_addr), .run_mode(run_mode)
    );

    sdram_init_port #(.ROW_W(12), .ROW_LSB(12)) u_sdram_init_port_small (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_ready(s_ready), .mem_cke(s_cke),
        .mem_ras_n(s_ras), .mem_cas_n(s_cas), .mem_we_n(s_we),
        .mem_ba(s_ba), .mem_addr(s_addr), .run_mode(s_run)
    );

    function automatic logic [31:0] f_row13(logic [31:0] a); return {19'd0, a[25:13]}; endfunction
    function automatic logic [31:0] f_bank13(logic [31:0] a); return {30'd0, a[12:11]}; endfunction
    function automatic logic [31:0] f_row12(logic [31:0] a); return {20'd0, a[23:12]}; endfunction
    function automatic logic [31:0] f_bank12(logic [31:0] a); return {30'd0, a[11:10]}; endfunction
    function automatic logic [31:0] f_cmd(logic [31:0] a); return {29'd0, a[6:4]}; endfunction
    function automatic logic [31:0] mk_addr(int row, int bank, int cmd);
        return (row << 13) | (bank << 11) | (cmd << 4);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_idle(string req);
        check({req, " cmd"}, {29'd0, ras_n, cas_n, we_n}, 32'd7);
        check({req, " addr"}, {19'd0, mem_addr}, 32'd0);
        check({req, " ba"}, {30'd0, mem_ba}, 32'd0);
        check({req, " ready"}, {31'd0, bus_ready}, 32'd0);
        check({req, " cke"}, {31'd0, mem_cke}, {31'd0, exp_cke});
    endtask

    // One write access, then check the issued cycle and the idle cycle after it.
    task automatic do_write(logic [31:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 1'b0;
        if (!exp_run) begin
            if (a[6:4] == 3'b111) exp_cke = 1'b1;
            check("R1 row", {19'd0, mem_addr}, f_row13(a));
            check("R2 bank", {30'd0, mem_ba}, f_bank13(a));
            check("R3 cmd", {29'd0, ras_n, cas_n, we_n}, f_cmd(a));
            check("R5 ready", {31'd0, bus_ready}, 32'd1);
            check("R6 cke", {31'd0, mem_cke}, {31'd0, exp_cke});
            check("R10 row", {20'd0, s_addr}, f_row12(a));
            check("R10 bank", {30'd0, s_ba}, f_bank12(a));
        end else begin
            check_idle("R8 normal write");
        end
        @(posedge clk); #1;
        check_idle("R4 after cmd");
    endtask

    task automatic do_read();
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 32'h1000_0000;
        @(posedge clk); #1;
        bus_sel = 1'b0;
        exp_run = 1'b1;
        check("R7 run set", {31'd0, run_mode}, 32'd1);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic [31:0] ra;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset run", {31'd0, run_mode}, 32'd0);
        check_idle("R9 reset");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check_idle("R9 after reset");
        check("R9 run after reset", {31'd0, run_mode}, 32'd0);

        // Directed power-up sequence; non-NOP commands before the first NOP.
        do_write(mk_addr(13'h400, 0, 2));
        check("R6 cke low before nop", {31'd0, mem_cke}, 32'd0);
        do_write(mk_addr(0, 0, 7));
        check("R6 cke high", {31'd0, mem_cke}, 32'd1);
        do_write(mk_addr(13'h400, 0, 2));
        do_write(mk_addr(13'h001, 1, 0));
        do_write(mk_addr(13'h121, 0, 0));
        do_write(mk_addr(0, 0, 1));
        do_write(mk_addr(13'h1FFF, 3, 5));
        do_write(32'hFFFF_FFFF);

        // Back-to-back writes: each held one clock.
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = mk_addr(13'h0AA, 2, 1);
        @(posedge clk); #1;
        check("R4 b2b first", {29'd0, ras_n, cas_n, we_n}, 32'd1);
        bus_addr = mk_addr(13'h155, 1, 2);
        @(posedge clk); #1;
        bus_sel = 1'b0;
        check("R4 b2b second cmd", {29'd0, ras_n, cas_n, we_n}, 32'd2);
        check("R4 b2b second row", {19'd0, mem_addr}, 32'h155);
        check("R5 b2b ready", {31'd0, bus_ready}, 32'd1);
        @(posedge clk); #1;
        check_idle("R4 b2b idle");

        // Random init-mode writes.
        for (int i = 0; i < 80; i++) begin
            ra = $urandom;
            do_write(ra);
        end

        // Switch to normal mode; writes no longer decoded.
        check("R7 run before read", {31'd0, run_mode}, 32'd0);
        do_read();
        check("R7 small run", {31'd0, s_run}, 32'd1);
        for (int i = 0; i < 10; i++) begin
            ra = $urandom;
            do_write(ra);
            check("R7 run sticky", {31'd0, run_mode}, 32'd1);
        end
        do_write(mk_addr(0, 0, 7));
        check("R8 cke unchanged", {31'd0, mem_cke}, {31'd0, exp_cke});

        // Reset returns to init mode.
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        exp_cke = 1'b0; exp_run = 1'b0;
        check("R9 rereset run", {31'd0, run_mode}, 32'd0);
        check_idle("R9 rereset");
        @(negedge clk); rst_n = 1'b1;
        do_write(mk_addr(13'h0F0, 2, 0));
        check("R6 cke low after rereset", {31'd0, mem_cke}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule